// File: doc/BRIEF.md
# DMA Cycle-Stealing Bus Arbiter

This block shares one address bus between a processor core and a byte-fetch DMA requester, such as a sample channel that needs a new byte now and then. The processor is never tri-stated. Instead, its ready input is pulled low. A halted processor keeps its current read address on the bus, so each stall cycle becomes a real read whose data nobody uses. The block marks each such cycle with a `dummy_rd` flag.

A DMA request is a one-cycle pulse carrying an address. The block queues the request and waits for a processor read cycle. It then holds the processor for three cycles, each of which re-reads the processor's address. On the fourth cycle it places the queued DMA address on the bus and hands the returned byte to the requester with `dma_ack`. On the fifth cycle it releases the processor, which repeats its stalled read and this time keeps the data.

A request that arrives while the processor is writing waits for the next read cycle. A request that arrives while a sequence is running is queued and served later. The FSM states are:

- `ST_IDLE`: processor owns the bus. A stall starts here, as a Mealy decision, when a request is queued and the current cycle is a read. This starting cycle is the first stall cycle. The transition `ST_IDLE`→`ST_HOLD_B` happens on that start.
- `ST_HOLD_B` and `ST_HOLD_C`: the second and third stall cycles. Transitions `ST_HOLD_B`→`ST_HOLD_C`→`ST_FETCH` are unconditional.
- `ST_FETCH`: the DMA slot. The transition `ST_FETCH`→`ST_RESUME` is unconditional.
- `ST_RESUME`: the processor's repeated read. No new sequence may start in this state. The transition `ST_RESUME`→`ST_IDLE` is unconditional.

Top module: `dma_steal_arb`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to idle with an empty request queue. After that edge, `cpu_rdy`=1, `dummy_rd`=0 and `dma_ack`=0.
- R2: In idle with no queued request, `bus_addr`=`cpu_addr`, `bus_rnw`=`cpu_rnw` and `cpu_rdy`=1. `bus_rnw`=1 means a read and 0 means a write.
- R3: When a queued request meets a processor read cycle, that cycle and the next two are stall cycles. In each of them, `cpu_rdy`=0, `dummy_rd`=1, `bus_rnw`=1 and `bus_addr`=`cpu_addr`.
- R4: The cycle after the third stall cycle is the DMA slot, with `bus_rnw`=1, `cpu_rdy`=0, `dummy_rd`=0, `dma_ack`=1 and `dma_data`=`bus_rdata`.
- R5: The cycle after the DMA slot releases the processor. In it, `cpu_rdy`=1, `dummy_rd`=0 and the bus follows the processor. No new sequence starts in this cycle, even with requests queued.
- R6: While a request is queued, processor write cycles are not stalled. They pass with `cpu_rdy`=1 and `bus_rnw`=0, and the stall starts on the first later read cycle.
- R7: A request pulse sampled at a clock edge can start a stall in the cycle right after that edge, but not in the cycle of the pulse itself.
- R8: Up to `PEND_DEPTH` outstanding requests are kept, including requests that arrive during a sequence. Each is served once, in arrival order, and its address is what `bus_addr` carries in its DMA slot.
- R9: `dma_data` is zero whenever `dma_ack` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | AW | Processor bus address |
| cpu_rnw | input | 1 | Processor cycle type: 1 read, 0 write |
| cpu_rdy | output | 1 | Ready to the processor; 0 halts it |
| cpu_rdata | output | DW | Read data toward the processor (valid when `cpu_rdy`=1) |
| dma_req | input | 1 | One-cycle DMA fetch request |
| dma_addr | input | AW | Address for the requested fetch, sampled with `dma_req` |
| dma_ack | output | 1 | High in the DMA slot |
| dma_data | output | DW | Fetched byte, valid with `dma_ack` |
| dummy_rd | output | 1 | High on each stall cycle whose read data is discarded |
| bus_addr | output | AW | Shared bus address |
| bus_rnw | output | 1 | Shared bus direction: 1 read, 0 write |
| bus_rdata | input | DW | Read data returned by the bus in the same cycle |

## Verification
The main function is driven with several input patterns, each meant to separate correct from incorrect behaviour:
- A lone request during steady reads checks the exact 3+1+1 cycle shape.
- A request followed by a run of writes separates a correct deferral from a stall that starts on a write.
- Requests pulsed inside a running sequence, including in the release cycle, show whether a queued request is dropped, served out of order, or wrongly started in the release cycle.
- A long mixed run of reads, writes and request bursts up to the queue depth is compared on every cycle against a behavioural model built on a queue and a phase counter.

// File: rtl/dma_steal_pkg.sv
package dma_steal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_HOLD_B = 3'd1,
        ST_HOLD_C = 3'd2,
        ST_FETCH  = 3'd3,
        ST_RESUME = 3'd4
    } arb_state_t;

endpackage

// File: rtl/dma_req_fifo.sv
module dma_req_fifo #(
    parameter int AW    = 16,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic          pop,
    output logic [AW-1:0] head_addr,
    output logic          not_empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [AW-1:0] slots [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign not_empty = (cnt != '0);
    assign full      = (cnt == CW'(DEPTH));
    assign do_push   = push && !full;
    assign do_pop    = pop && not_empty;
    assign head_addr = slots[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                slots[wp] <= push_addr;
                wp        <= bump(wp);
            end
            if (do_pop) begin
                rp <= bump(rp);
            end
            unique case ({do_push, do_pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/dma_steal_fsm.sv
module dma_steal_fsm
    import dma_steal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cpu_rnw,
    input  logic pend_valid,
    output logic cpu_rdy,
    output logic dummy_rd,
    output logic fetch
);
    arb_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        cpu_rdy  = 1'b1;
        dummy_rd = 1'b0;
        fetch    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (pend_valid && cpu_rnw) begin
                    cpu_rdy  = 1'b0;
                    dummy_rd = 1'b1;
                    state_d  = ST_HOLD_B;
                end
            end
            ST_HOLD_B: begin
                cpu_rdy  = 1'b0;
                dummy_rd = 1'b1;
                state_d  = ST_HOLD_C;
            end
            ST_HOLD_C: begin
                cpu_rdy  = 1'b0;
                dummy_rd = 1'b1;
                state_d  = ST_FETCH;
            end
            ST_FETCH: begin
                cpu_rdy = 1'b0;
                fetch   = 1'b1;
                state_d = ST_RESUME;
            end
            ST_RESUME: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/dma_steal_arb.sv
module dma_steal_arb #(
    parameter int AW         = 16,
    parameter int DW         = 8,
    parameter int PEND_DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] cpu_addr,
    input  logic          cpu_rnw,
    output logic          cpu_rdy,
    output logic [DW-1:0] cpu_rdata,
    input  logic          dma_req,
    input  logic [AW-1:0] dma_addr,
    output logic          dma_ack,
    output logic [DW-1:0] dma_data,
    output logic          dummy_rd,
    output logic [AW-1:0] bus_addr,
    output logic          bus_rnw,
    input  logic [DW-1:0] bus_rdata
);
    logic          q_valid;
    logic          q_full;
    logic [AW-1:0] q_head;
    logic          fetch;

    dma_req_fifo #(
        .AW    (AW),
        .DEPTH (PEND_DEPTH)
    ) req_q_i (
        .clk       (clk),
        .rst       (rst),
        .push      (dma_req),
        .push_addr (dma_addr),
        .pop       (fetch),
        .head_addr (q_head),
        .not_empty (q_valid),
        .full      (q_full)
    );

    dma_steal_fsm fsm_i (
        .clk        (clk),
        .rst        (rst),
        .cpu_rnw    (cpu_rnw),
        .pend_valid (q_valid),
        .cpu_rdy    (cpu_rdy),
        .dummy_rd   (dummy_rd),
        .fetch      (fetch)
    );

    always_comb begin
        bus_addr = fetch ? q_head : cpu_addr;
        bus_rnw  = (fetch || dummy_rd) ? 1'b1 : cpu_rnw;
        dma_ack  = fetch;
        dma_data = fetch ? bus_rdata : '0;
    end

    assign cpu_rdata = bus_rdata;

endmodule

// File: rtl/dma_steal_chk.sv
module dma_steal_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] cpu_addr,
    input logic          cpu_rnw,
    input logic          cpu_rdy,
    input logic          dummy_rd,
    input logic          dma_ack,
    input logic [AW-1:0] bus_addr,
    input logic          bus_rnw,
    input logic          dma_req,
    input logic          q_full
);
    AST_HOLD_RDY_LOW: assert property (@(posedge clk) disable iff (rst) dummy_rd |-> !cpu_rdy); // R3
    AST_HOLD_CPU_ADDR: assert property (@(posedge clk) disable iff (rst) dummy_rd |-> (bus_addr == cpu_addr) && bus_rnw); // R3
    AST_FETCH_AFTER_HOLDS: assert property (@(posedge clk) disable iff (rst) dma_ack |-> $past(dummy_rd, 1) && $past(dummy_rd, 2) && $past(dummy_rd, 3)); // R4
    AST_FETCH_IS_READ: assert property (@(posedge clk) disable iff (rst) dma_ack |-> bus_rnw && !cpu_rdy && !dummy_rd); // R4
    AST_RESUME_AFTER_FETCH: assert property (@(posedge clk) disable iff (rst) dma_ack |=> cpu_rdy && !dummy_rd && !dma_ack); // R5
    AST_START_ON_READ: assert property (@(posedge clk) disable iff (rst) (dummy_rd && !$past(dummy_rd)) |-> cpu_rnw); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) !(dma_req && q_full)); // R8
endmodule

bind dma_steal_arb dma_steal_chk #(.AW(AW)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .cpu_addr (cpu_addr),
    .cpu_rnw  (cpu_rnw),
    .cpu_rdy  (cpu_rdy),
    .dummy_rd (dummy_rd),
    .dma_ack  (dma_ack),
    .bus_addr (bus_addr),
    .bus_rnw  (bus_rnw),
    .dma_req  (dma_req),
    .q_full   (q_full)
);

// File: tb/dma_steal_arb_tb_top.sv
module dma_steal_arb_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int DEPTH = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_rnw = 1'b1;
    logic          cpu_rdy;
    logic [DW-1:0] cpu_rdata;
    logic          dma_req = 1'b0;
    logic [AW-1:0] dma_addr = '0;
    logic          dma_ack;
    logic [DW-1:0] dma_data;
    logic          dummy_rd;
    logic [AW-1:0] bus_addr;
    logic          bus_rnw;
    logic [DW-1:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;

    logic [AW-1:0] mq[$];
    int            phase = 0;
    bit            last_rdy = 1'b1;
    bit            last_req = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DW-1:0] memf(input logic [AW-1:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    assign bus_rdata = memf(bus_addr);

    dma_steal_arb #(.AW(AW), .DW(DW), .PEND_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rnw(cpu_rnw),
        .cpu_rdy(cpu_rdy), .cpu_rdata(cpu_rdata), .dma_req(dma_req),
        .dma_addr(dma_addr), .dma_ack(dma_ack), .dma_data(dma_data),
        .dummy_rd(dummy_rd), .bus_addr(bus_addr), .bus_rnw(bus_rnw),
        .bus_rdata(bus_rdata)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One bus cycle: drive at the falling edge, compare 1 time unit later, advance the model.
    task automatic step(input bit rnw, input logic [AW-1:0] a, input bit req, input logic [AW-1:0] da);
        bit            e_rdy, e_dum, e_ack, e_rnw, start;
        logic [AW-1:0] e_addr;
        string         tag;
        @(negedge clk);
        if (last_rdy) begin
            cpu_rnw  = rnw;
            cpu_addr = a;
        end
        dma_req  = req && (mq.size() < DEPTH);
        dma_addr = da;
        #1;
        start  = 1'b0;
        e_rdy  = 1'b1; e_dum = 1'b0; e_ack = 1'b0;
        e_addr = cpu_addr; e_rnw = cpu_rnw;
        case (phase)
            0: begin
                start = (mq.size() > 0) && cpu_rnw;
                if (start) begin
                    e_rdy = 1'b0; e_dum = 1'b1; e_rnw = 1'b1;
                    tag = (last_req && mq.size() == 1) ? "R7" : "R3";
                end else if (mq.size() > 0) begin
                    tag = "R6";
                end else begin
                    tag = "R2";
                end
            end
            1, 2: begin
                e_rdy = 1'b0; e_dum = 1'b1; e_rnw = 1'b1; tag = "R3";
            end
            3: begin
                e_rdy = 1'b0; e_ack = 1'b1; e_rnw = 1'b1; e_addr = mq[0]; tag = "R4";
            end
            default: tag = "R5";
        endcase
        chk(cpu_rdy == e_rdy, tag, "cpu_rdy", 32'(cpu_rdy), 32'(e_rdy));
        chk(dummy_rd == e_dum, tag, "dummy_rd", 32'(dummy_rd), 32'(e_dum));
        chk(dma_ack == e_ack, tag, "dma_ack", 32'(dma_ack), 32'(e_ack));
        chk(bus_addr == e_addr, (phase == 3) ? "R8" : tag, "bus_addr", 32'(bus_addr), 32'(e_addr));
        chk(bus_rnw == e_rnw, tag, "bus_rnw", 32'(bus_rnw), 32'(e_rnw));
        if (e_ack)
            chk(dma_data == memf(e_addr), "R4", "dma_data", 32'(dma_data), 32'(memf(e_addr)));
        else
            chk(dma_data == '0, "R9", "dma_data", 32'(dma_data), 32'h0);
        // model update for the coming edge
        case (phase)
            0: phase = start ? 1 : 0;
            1: phase = 2;
            2: phase = 3;
            3: begin void'(mq.pop_front()); phase = 4; end
            default: phase = 0;
        endcase
        if (dma_req) mq.push_back(dma_addr);
        last_req = dma_req;
        last_rdy = e_rdy;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk(cpu_rdy == 1'b1, "R1", "cpu_rdy", 32'(cpu_rdy), 32'h1);
        chk(dummy_rd == 1'b0, "R1", "dummy_rd", 32'(dummy_rd), 32'h0);
        chk(dma_ack == 1'b0, "R1", "dma_ack", 32'(dma_ack), 32'h0);
        @(negedge clk);
        rst = 1'b0;
        // idle reads and writes
        for (int i = 0; i < 20; i++) step(i[0], 16'h1000 + 16'(i), 1'b0, '0);
        // lone request during reads
        step(1'b1, 16'h4016, 1'b1, 16'hC000);
        for (int i = 0; i < 10; i++) step(1'b1, 16'h4016, 1'b0, '0);
        // request then a run of writes
        step(1'b1, 16'h0200, 1'b1, 16'hC001);
        for (int i = 0; i < 6; i++) step(1'b0, 16'h0300 + 16'(i), 1'b0, '0);
        for (int i = 0; i < 8; i++) step(1'b1, 16'h4017, 1'b0, '0);
        // requests inside a running sequence, including the release cycle
        step(1'b1, 16'h4016, 1'b1, 16'hC010);
        step(1'b1, 16'h4016, 1'b0, '0);
        step(1'b1, 16'h4016, 1'b1, 16'hC011);
        step(1'b1, 16'h4016, 1'b0, '0);
        step(1'b1, 16'h4016, 1'b1, 16'hC012);
        step(1'b1, 16'h4016, 1'b1, 16'hC013);
        for (int i = 0; i < 30; i++) step(1'b1, 16'h4016, 1'b0, '0);
        // mixed run
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r = $urandom;
            step(r[2:0] != 3'd0, r[31:16], r[7:4] < 4'd3, {8'hC0, r[15:8]});
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule